// File: doc/BRIEF.md
# I2C Serial Clock Generator with Wired-AND Synchronization

This block produces the serial clock of a two-wire bus from the system clock while its owner acts as a bus master. It controls an open-drain pad by asserting a pull-low enable; it never drives the line high. A 3-bit select code chooses one of a fixed set of half-period lengths. The low and high halves use the same count.

The generator reads back the actual line level through a synchronizer. This lets it cooperate with other devices that share the line. Any device that pulls the line low starts the generator's own low phase. After its own low count ends, the generator releases the line and does not start counting high time until the line is really high. The shared clock therefore takes the longest low period of all devices, and a slow target can stretch it.

Three single-cycle strobes are provided for the byte-level logic that sits around this block: one for the line's rising edge, one for its falling edge, and one for the middle of each high phase.

Top module: `scl_clock_gen`

## Requirements
- R1: While `rst_n` is low, and while `master_en` is low, `scl_drive_low` is 0 and `scl_mid_high` is 0.
- R2: One cycle after `master_en` is sampled high while the generator is idle, `scl_drive_low` is 1. That low phase starts with its counter cleared and lasts a full half-period, even if an earlier low phase was cut short by disabling.
- R3: `div_sel` chooses the half-period H in system clocks: code 0 gives 128, 1 gives 112, 2 gives 96, 3 gives 80, 4 gives 480, 5 gives 60, 6 gives 30 and 7 gives 30.
- R4: In each low phase, `scl_drive_low` stays asserted for exactly H consecutive cycles.
- R5: After the generator releases the line, it keeps `scl_drive_low` at 0 for as long as the synchronized line stays low, however long that is.
- R6: After the line goes high with no outside interference, `scl_drive_low` asserts again H+3 cycles later: 2 cycles of synchronizer latency, 1 cycle of phase change, then H high cycles.
- R7: If the line is pulled low from outside during the high phase, `scl_drive_low` asserts 3 cycles after the line falls. It then stays asserted for a fresh H cycles.
- R8: The sensed line passes through two flops. `scl_rise` and `scl_fall` each give one single-cycle pulse per line transition, 2 cycles after it.
- R9: `scl_mid_high` pulses exactly once per complete high phase, on its count H/2.
- R10: One cycle after `master_en` is sampled low, `scl_drive_low` is 0, whatever phase was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | High while the module acts as bus master |
| div_sel | input | 3 | Half-period select code |
| scl_in | input | 1 | Sensed level of the shared clock line |
| scl_drive_low | output | 1 | Open-drain pull-low enable for the clock pad |
| scl_rise | output | 1 | Pulse on a synchronized rising edge of the line |
| scl_fall | output | 1 | Pulse on a synchronized falling edge of the line |
| scl_mid_high | output | 1 | Pulse in the middle of each high phase |

## Verification
The bench holds the line low from outside at the moment the generator releases it, for stretches from one cycle to several hundred. A design that starts its high count on its own release, instead of on the sensed line, would shorten the high phase and fail the H+2 count taken from the outside release. A second test pulls the line low in the middle of a high phase. A generator that ignored the outside low, or failed to restart its low count, would either show a wrong 3-cycle reaction or give a low phase other than H. The bench also disables the generator partway through a low phase and enables it again. A counter that was not cleared would give a short low phase, and a release path that depended on the phase would leave the pad pulled low.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int SEL_W = 3;
    localparam int CNT_W = 10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   half;
    } gen_st_t;

endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    // Index STAGES-1 is the synchronized level; index STAGES holds its previous value.
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

    // R8: an edge strobe never lasts two cycles
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sclgen_halfsel.sv
module sclgen_halfsel
    import sclgen_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] half_o
);

    always_comb begin
        unique case (sel_i)
            3'd0:    half_o = CNT_W'(128);
            3'd1:    half_o = CNT_W'(112);
            3'd2:    half_o = CNT_W'(96);
            3'd3:    half_o = CNT_W'(80);
            3'd4:    half_o = CNT_W'(480);
            3'd5:    half_o = CNT_W'(60);
            default: half_o = CNT_W'(30);
        endcase
    end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import sclgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic             scl_mid_high
);

    logic             line_lvl;
    logic [CNT_W-1:0] half_sel;
    gen_st_t          st_d, st_q;

    sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_in),
        .lvl_o  (line_lvl),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    sclgen_halfsel u_halfsel (
        .sel_i  (div_sel),
        .half_o (half_sel)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                st_d.ph   = PH_LOW;
                st_d.cnt  = '0;
                st_d.half = half_sel;
            end
            PH_LOW: begin
                if (st_q.cnt >= st_q.half - 1'b1) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                // High time is counted only once the shared line is seen high
                if (line_lvl) begin
                    st_d.ph   = PH_HIGH;
                    st_d.cnt  = '0;
                    st_d.half = half_sel;
                end
            end
            PH_HIGH: begin
                if (!line_lvl || st_q.cnt >= st_q.half - 1'b1) begin
                    st_d.ph   = PH_LOW;
                    st_d.cnt  = '0;
                    st_d.half = half_sel;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase
        if (!master_en) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.half <= CNT_W'(30);
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_drive_low = (st_q.ph == PH_LOW);
    assign scl_mid_high  = (st_q.ph == PH_HIGH) && (st_q.cnt == (st_q.half >> 1));

    // R2: enabling starts a low phase on the next cycle
    a_r2_enable_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_en) |=> scl_drive_low);

    // R10: disabling releases the line on the next cycle
    a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !scl_drive_low);

    // R5: while waiting for the line to rise, the pad stays released
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_WAIT && !line_lvl && master_en) |=> !scl_drive_low);

    // R7: an outside low during the high phase pulls the generator into low
    a_r7_high_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HIGH && !line_lvl && master_en) |=> scl_drive_low);

endmodule

// File: tb/scl_clock_gen_bench.sv
module scl_clock_gen_bench;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] stretch;
        logic [9:0]  half;
    } vec_t;

    // half values follow the R3 code table
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 16'd0,   10'd128},
        '{3'd1, 16'd0,   10'd112},
        '{3'd2, 16'd40,  10'd96},
        '{3'd3, 16'd0,   10'd80},
        '{3'd4, 16'd0,   10'd480},
        '{3'd5, 16'd200, 10'd60},
        '{3'd6, 16'd0,   10'd30},
        '{3'd7, 16'd0,   10'd30},
        '{3'd6, 16'd500, 10'd30},
        '{3'd3, 16'd1,   10'd80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       ext_low = 1'b0;
    logic       drv, rise, fall, mid;
    logic       scl_line;

    assign scl_line = ~(drv | ext_low);

    always #5 clk = ~clk;

    scl_clock_gen u_scl_clock_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_en     (en),
        .div_sel       (sel),
        .scl_in        (scl_line),
        .scl_drive_low (drv),
        .scl_rise      (rise),
        .scl_fall      (fall),
        .scl_mid_high  (mid)
    );

    int nchk = 0;
    int nbad = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gap();
        en = 1'b0;
        ext_low = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic count_low(output int lowc, output int fallc);
        lowc = 0;
        fallc = 0;
        while (drv) begin
            lowc++;
            if (fall) fallc++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int lowc, fallc, highc, risec, midc, held;
        gap();
        sel = v.sel;
        en = 1'b1;
        @(negedge clk);
        chk("R2 start", int'(drv), 1);
        lowc = 0;
        fallc = 0;
        while (drv) begin
            lowc++;
            if (fall) fallc++;
            if (v.stretch != 0) ext_low = 1'b1;
            @(negedge clk);
        end
        chk("R3 R4 low length", lowc, int'(v.half));
        chk("R8 fall strobe", fallc, 1);
        if (v.stretch != 0) begin
            held = 1;
            for (int i = 0; i < int'(v.stretch); i++) begin
                if (drv) held = 0;
                if (i == int'(v.stretch) - 1) ext_low = 1'b0;
                @(negedge clk);
            end
            chk("R5 stretch held", held, 1);
        end
        highc = 0;
        risec = 0;
        midc = 0;
        while (!drv) begin
            highc++;
            if (rise) risec++;
            if (mid) midc++;
            @(negedge clk);
        end
        chk("R6 high length", highc, int'(v.half) + ((v.stretch != 0) ? 2 : 3));
        chk("R8 rise strobe", risec, 1);
        chk("R9 mid strobe", midc, 1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int lowc, fallc, cnt, ok;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset drive", int'(drv), 0);
        chk("R1 reset mid", int'(mid), 0);
        rst_n = 1'b1;
        ok = 1;
        repeat (10) begin
            @(negedge clk);
            if (drv || mid) ok = 0;
        end
        chk("R1 disabled quiet", ok, 1);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // R7: outside low during the high phase
        gap();
        sel = 3'd6;
        en = 1'b1;
        @(negedge clk);
        count_low(lowc, fallc);
        while (!mid) @(negedge clk);
        ext_low = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!drv && cnt < 50);
        chk("R7 reaction cycles", cnt, 3);
        lowc = 0;
        while (drv) begin
            lowc++;
            if (lowc == 5) ext_low = 1'b0;
            @(negedge clk);
        end
        chk("R7 restarted low length", lowc, 30);

        // R10 / R2: disable partway through a low phase, then enable again
        gap();
        sel = 3'd5;
        en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 still low before disable", int'(drv), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R10 release", int'(drv), 0);
        ok = 1;
        repeat (20) begin
            @(negedge clk);
            if (drv || mid) ok = 0;
        end
        chk("R1 idle after disable", ok, 1);
        en = 1'b1;
        @(negedge clk);
        chk("R2 restart", int'(drv), 1);
        count_low(lowc, fallc);
        chk("R2 counter cleared", lowc, 60);

        summary();
        $finish;
    end

endmodule